// File: doc/BRIEF.md
# DMA Global Control Register Block

This block is the shared register file of a multi-channel DMA controller. It sits on a simple 32-bit register bus and holds the settings and status that apply to the whole controller. That covers a global enable, two sticky summary flags for channel halt and address error, and two plain performance-option bits. It also holds a per-channel interrupt-pending vector, a doorbell vector that issues single-cycle descriptor-fetch requests to the channel engines, a per-channel clock-enable vector with set and clear aliases, and a programmable-channel mask.

Each channel engine reports three kinds of event: termination, halt and address error. Any of them latches that channel's pending bit. A halt or address error from any channel also latches the matching summary flag in the control word. Software acknowledges pending bits by writing the pending register back with the handled bits at zero. It clears the summary flags in the same way, by writing the control word back with those bits at zero. The interrupt line combines all pending bits and is gated by the global enable.

Top module: `dma_gctl_regs`

## Requirements
- R1: After reset every register address reads zero, all clock enables are off, no fetch request is active and the interrupt is low.
- R2: Control word (word 0, byte 0x00): bit 0 (global enable), bit 27 and bit 31 are read/write. Every other bit reads zero, except the summary flags in R3.
- R3: Control bit 3 (halt summary) is set in the cycle after any channel asserts its halt event. Control bit 2 (address-error summary) is set in the same way by any address-error event. Writing 0 to either bit clears it, and writing 1 leaves it unchanged. An event in the same cycle as a clearing write keeps the bit set.
- R4: Pending bit n (word 1, byte 0x04) is set in the cycle after channel n asserts its termination, halt or address-error event.
- R5: A write to the pending register clears each bit written as 0 and leaves each bit written as 1 unchanged. An event on channel n in the same cycle as the write keeps bit n set.
- R6: The interrupt output is high exactly when the global enable is set and at least one pending bit is set.
- R7: Writing 1 to bit n of the doorbell-set address (byte 0x0C) sets doorbell bit n, which reads back at both byte 0x08 and byte 0x0C from the next cycle. The fetch request for channel n is high for exactly the one cycle that follows, and the doorbell bit is cleared one cycle after that pulse. Zero bits have no effect, and writes to byte 0x08 are ignored.
- R8: The clock-enable register (byte 0x10) is read/write, and its value drives the per-channel clock-enable outputs.
- R9: Writing 1 to bit n at byte 0x14 sets clock enable n, and writing 1 to bit n at byte 0x18 clears it. Zero bits have no effect. Both alias addresses read back the clock-enable value.
- R10: The programmable-channel mask (byte 0x1C) is read/write for one bit per channel.
- R11: In every per-channel register, bits at or above the channel count read zero and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe for the current bus cycle |
| busAddr | input | ADDR_W | Byte address of the access (word aligned) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| evTerm | input | NUM_CH | Per-channel termination event |
| evHalt | input | NUM_CH | Per-channel halt event |
| evAddrErr | input | NUM_CH | Per-channel address-error event |
| fetchReq | output | NUM_CH | Per-channel single-cycle descriptor-fetch request |
| clkEn | output | NUM_CH | Per-channel clock enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a single bus write per cycle and events that are sampled as synchronous levels on the rising edge. They also assume that a rise of the interrupt can only follow an event or a bus write, which holds because nothing else in the block changes state. The stimulus keeps to this. It changes every input only on the falling edge and holds each event or write for exactly one rising edge. It issues writes strictly one after another, and places events alongside writes only where R3 and R5 call for the same-cycle collision.

// File: rtl/dma_gctl_pkg.sv
package dma_gctl_pkg;
  localparam int BUS_W = 32;

  // word indices of the register map (byte offset = index * 4)
  localparam int WI_CTRL  = 0;
  localparam int WI_PEND  = 1;
  localparam int WI_DB    = 2;
  localparam int WI_DBSET = 3;
  localparam int WI_CKEN  = 4;
  localparam int WI_CKSET = 5;
  localparam int WI_CKCLR = 6;
  localparam int WI_MASK  = 7;

  // control word bit positions
  localparam int BIT_EN    = 0;
  localparam int BIT_AERR  = 2;
  localparam int BIT_HALT  = 3;
  localparam int BIT_PERFA = 27;
  localparam int BIT_PERFB = 31;

  typedef struct packed {
    logic ctrl;
    logic pend;
    logic dbSet;
    logic ckEn;
    logic ckSet;
    logic ckClr;
    logic chMask;
  } wrStrobe_t;

  typedef enum logic [2:0] {
    RS_CTRL  = 3'd0,
    RS_PEND  = 3'd1,
    RS_DB    = 3'd2,
    RS_DBSET = 3'd3,
    RS_CKEN  = 3'd4,
    RS_CKSET = 3'd5,
    RS_CKCLR = 3'd6,
    RS_MASK  = 3'd7
  } rdSel_t;
endpackage

// File: rtl/dma_gctl_decode.sv
module dma_gctl_decode
  import dma_gctl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output wrStrobe_t         wrStb,
  output rdSel_t            rdSel,
  output logic              inMap
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic [1:0]       unusedLow;
  int unsigned      idxU;

  assign wordIdx   = busAddr[ADDR_W-1:2];
  assign unusedLow = busAddr[1:0];

  always_comb begin
    idxU  = 32'(wordIdx);
    inMap = (idxU <= 32'(WI_MASK));
    rdSel = rdSel_t'(wordIdx[2:0]);
    wrStb = '0;
    if (busWrEn && inMap) begin
      unique case (idxU)
        WI_CTRL:  wrStb.ctrl   = 1'b1;
        WI_PEND:  wrStb.pend   = 1'b1;
        WI_DBSET: wrStb.dbSet  = 1'b1;
        WI_CKEN:  wrStb.ckEn   = 1'b1;
        WI_CKSET: wrStb.ckSet  = 1'b1;
        WI_CKCLR: wrStb.ckClr  = 1'b1;
        WI_MASK:  wrStb.chMask = 1'b1;
        default:  ; // doorbell status word is read-only
      endcase
    end
  end
endmodule

// File: rtl/dma_gctl_datapath.sv
module dma_gctl_datapath
  import dma_gctl_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         wrStb,
  input  rdSel_t            rdSel,
  input  logic              inMap,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [NUM_CH-1:0] evTerm,
  input  logic [NUM_CH-1:0] evHalt,
  input  logic [NUM_CH-1:0] evAddrErr,
  output logic [BUS_W-1:0]  rdData,
  output logic [NUM_CH-1:0] fetchReq,
  output logic [NUM_CH-1:0] clkEn,
  output logic              irq,
  output logic [NUM_CH-1:0] pendVec,
  output logic              globEn,
  output logic              haltSum,
  output logic              addrErrSum
);
  logic [NUM_CH-1:0] evAny;
  logic [NUM_CH-1:0] pendQ, dbQ, reqQ, ckQ, maskQ;
  logic [NUM_CH-1:0] wdCh;
  logic              enQ, perfAQ, perfBQ, haltQ, aerrQ;
  logic [BUS_W-1:0]  ctrlWord;
  logic              unusedWd;

  assign evAny    = evTerm | evHalt | evAddrErr;
  assign wdCh     = wrData[NUM_CH-1:0];
  assign unusedWd = ^wrData;

  // global control word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      perfAQ <= 1'b0;
      perfBQ <= 1'b0;
      haltQ  <= 1'b0;
      aerrQ  <= 1'b0;
    end else begin
      if (wrStb.ctrl) begin
        enQ    <= wrData[BIT_EN];
        perfAQ <= wrData[BIT_PERFA];
        perfBQ <= wrData[BIT_PERFB];
      end
      if (|evHalt)                               haltQ <= 1'b1;
      else if (wrStb.ctrl && !wrData[BIT_HALT])  haltQ <= 1'b0;
      if (|evAddrErr)                            aerrQ <= 1'b1;
      else if (wrStb.ctrl && !wrData[BIT_AERR])  aerrQ <= 1'b0;
    end
  end

  // per-channel state slices
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ[ch] <= 1'b0;
        dbQ[ch]   <= 1'b0;
        reqQ[ch]  <= 1'b0;
        ckQ[ch]   <= 1'b0;
        maskQ[ch] <= 1'b0;
      end else begin
        if (evAny[ch])                       pendQ[ch] <= 1'b1;
        else if (wrStb.pend && !wdCh[ch])    pendQ[ch] <= 1'b0;

        reqQ[ch] <= dbQ[ch] & ~reqQ[ch];
        dbQ[ch]  <= (dbQ[ch] & ~reqQ[ch]) | (wrStb.dbSet & wdCh[ch]);

        if (wrStb.ckEn)                      ckQ[ch] <= wdCh[ch];
        else if (wrStb.ckSet && wdCh[ch])    ckQ[ch] <= 1'b1;
        else if (wrStb.ckClr && wdCh[ch])    ckQ[ch] <= 1'b0;

        if (wrStb.chMask)                    maskQ[ch] <= wdCh[ch];
      end
    end
  end

  always_comb begin
    ctrlWord            = '0;
    ctrlWord[BIT_EN]    = enQ;
    ctrlWord[BIT_AERR]  = aerrQ;
    ctrlWord[BIT_HALT]  = haltQ;
    ctrlWord[BIT_PERFA] = perfAQ;
    ctrlWord[BIT_PERFB] = perfBQ;
  end

  always_comb begin
    rdData = '0;
    if (inMap) begin
      unique case (rdSel)
        RS_CTRL:                    rdData = ctrlWord;
        RS_PEND:                    rdData[NUM_CH-1:0] = pendQ;
        RS_DB, RS_DBSET:            rdData[NUM_CH-1:0] = dbQ;
        RS_CKEN, RS_CKSET, RS_CKCLR: rdData[NUM_CH-1:0] = ckQ;
        RS_MASK:                    rdData[NUM_CH-1:0] = maskQ;
        default:                    rdData = '0;
      endcase
    end
  end

  assign fetchReq   = reqQ;
  assign clkEn      = ckQ;
  assign irq        = enQ & (|pendQ);
  assign pendVec    = pendQ;
  assign globEn     = enQ;
  assign haltSum    = haltQ;
  assign addrErrSum = aerrQ;
endmodule

// File: rtl/dma_gctl_regs.sv
module dma_gctl_regs
  import dma_gctl_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic [NUM_CH-1:0] evTerm,
  input  logic [NUM_CH-1:0] evHalt,
  input  logic [NUM_CH-1:0] evAddrErr,
  output logic [NUM_CH-1:0] fetchReq,
  output logic [NUM_CH-1:0] clkEn,
  output logic              irq
);
  wrStrobe_t         wrStb;
  rdSel_t            rdSel;
  logic              inMap;
  logic [NUM_CH-1:0] pendVec;
  logic              globEn, haltSum, addrErrSum;

  dma_gctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .wrStb   (wrStb),
    .rdSel   (rdSel),
    .inMap   (inMap)
  );

  dma_gctl_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrStb      (wrStb),
    .rdSel      (rdSel),
    .inMap      (inMap),
    .wrData     (busWrData),
    .evTerm     (evTerm),
    .evHalt     (evHalt),
    .evAddrErr  (evAddrErr),
    .rdData     (busRdData),
    .fetchReq   (fetchReq),
    .clkEn      (clkEn),
    .irq        (irq),
    .pendVec    (pendVec),
    .globEn     (globEn),
    .haltSum    (haltSum),
    .addrErrSum (addrErrSum)
  );
endmodule

// File: rtl/dma_gctl_regs_chk.sv
module dma_gctl_regs_chk
  import dma_gctl_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWrData,
  input logic [NUM_CH-1:0] evTerm,
  input logic [NUM_CH-1:0] evHalt,
  input logic [NUM_CH-1:0] evAddrErr,
  input logic [NUM_CH-1:0] fetchReq,
  input logic [NUM_CH-1:0] clkEn,
  input logic              irq,
  input logic [NUM_CH-1:0] pendVec,
  input logic              haltSum,
  input logic              addrErrSum
);
  logic [NUM_CH-1:0] evAll;
  logic [NUM_CH-1:0] wdCh;
  logic              wrCkSet, wrCkClr, wrAny;
  logic              unusedChk;

  assign evAll     = evTerm | evHalt | evAddrErr;
  assign wdCh      = busWrData[NUM_CH-1:0];
  assign wrCkSet   = busWrEn && (32'(busAddr) == 32'(WI_CKSET * 4));
  assign wrCkClr   = busWrEn && (32'(busAddr) == 32'(WI_CKCLR * 4));
  assign wrAny     = busWrEn;
  assign unusedChk = ^busWrData;

  AST_PEND_ON_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (|evAll) |=> ((pendVec & $past(evAll)) == $past(evAll))); // R4

  AST_HALT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|evHalt) |=> haltSum); // R3

  AST_AERR_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|evAddrErr) |=> addrErrSum); // R3

  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (|fetchReq) |=> ((fetchReq & $past(fetchReq)) == '0)); // R7

  AST_CKEN_SET: assert property (@(posedge clk) disable iff (!rstN)
    wrCkSet |=> ((clkEn & $past(wdCh)) == $past(wdCh))); // R9

  AST_CKEN_CLR: assert property (@(posedge clk) disable iff (!rstN)
    wrCkClr |=> ((clkEn & $past(wdCh)) == '0)); // R9

  AST_CKEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrAny |=> $stable(clkEn)); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(|evAll) || $past(wrAny))); // R6
endmodule

bind dma_gctl_regs dma_gctl_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .evTerm     (evTerm),
  .evHalt     (evHalt),
  .evAddrErr  (evAddrErr),
  .fetchReq   (fetchReq),
  .clkEn      (clkEn),
  .irq        (irq),
  .pendVec    (pendVec),
  .haltSum    (haltSum),
  .addrErrSum (addrErrSum)
);

// File: tb/dma_gctl_regs_bench.sv
`timescale 1ns/1ps
module dma_gctl_regs_bench;
  localparam int NUM_CH = 8;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [NUM_CH-1:0] evTerm = '0, evHalt = '0, evAddrErr = '0;
  logic [NUM_CH-1:0] fetchReq, clkEn;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_gctl_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dma_gctl_regs (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .evTerm(evTerm),
    .evHalt(evHalt), .evAddrErr(evAddrErr), .fetchReq(fetchReq),
    .clkEn(clkEn), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a[ADDR_W-1:0]; busWrData = d;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a[ADDR_W-1:0];
    #0.5;
    d = busRdData;
  endtask

  task automatic pulseEv(input logic [NUM_CH-1:0] t, input logic [NUM_CH-1:0] h, input logic [NUM_CH-1:0] e);
    evTerm = t; evHalt = h; evAddrErr = e;
    @(posedge clk); @(negedge clk);
    evTerm = '0; evHalt = '0; evAddrErr = '0;
  endtask

  task automatic tReset;
    logic [31:0] v;
    for (int w = 0; w < 8; w++) begin
      busRead(8'(w * 4), v);
      check("R1 reset readback", v, 32'h0);
    end
    check("R1 reset clkEn", 32'(clkEn), 32'h0);
    check("R1 reset fetchReq", 32'(fetchReq), 32'h0);
    check("R1 reset irq", 32'(irq), 32'h0);
  endtask

  task automatic tCtrl;
    logic [31:0] v;
    busWrite(8'h00, 32'hFFFF_FFFF);
    busRead(8'h00, v);
    check("R2 R3 ctrl write ones", v, 32'h8800_0001);
    busWrite(8'h00, 32'h0);
    busRead(8'h00, v);
    check("R2 ctrl write zero", v, 32'h0);
  endtask

  task automatic tSticky;
    logic [31:0] v;
    pulseEv('0, 8'h08, '0);
    busRead(8'h00, v);
    check("R3 halt summary", v, 32'h0000_0008);
    pulseEv('0, '0, 8'h01);
    busRead(8'h00, v);
    check("R3 addr-error summary", v, 32'h0000_000C);
    busWrite(8'h00, 32'h0000_0008);
    busRead(8'h00, v);
    check("R3 clear addr-error only", v, 32'h0000_0008);
    evHalt = 8'h02;
    busWrite(8'h00, 32'h0);
    evHalt = '0;
    busRead(8'h00, v);
    check("R3 event beats clear", v, 32'h0000_0008);
    busWrite(8'h00, 32'h0);
    busRead(8'h00, v);
    check("R3 clear halt", v, 32'h0);
    busWrite(8'h04, 32'h0);
  endtask

  task automatic tPending;
    logic [31:0] v;
    pulseEv(8'h02, 8'h10, 8'h40);
    busRead(8'h04, v);
    check("R4 pending from three event kinds", v, 32'h52);
    busWrite(8'h04, 32'hFF);
    busRead(8'h04, v);
    check("R5 write ones keeps", v, 32'h52);
    busWrite(8'h04, 32'hEF);
    busRead(8'h04, v);
    check("R5 write zero clears one bit", v, 32'h42);
    evTerm = 8'h02;
    busWrite(8'h04, 32'h0);
    evTerm = '0;
    busRead(8'h04, v);
    check("R5 event beats clear", v, 32'h02);
    busWrite(8'h04, 32'h0);
    busRead(8'h04, v);
    check("R5 clear all", v, 32'h0);
    busWrite(8'h00, 32'h0);
  endtask

  task automatic tIrq;
    pulseEv(8'h04, '0, '0);
    check("R6 irq gated off", 32'(irq), 32'h0);
    busWrite(8'h00, 32'h1);
    check("R6 irq enabled", 32'(irq), 32'h1);
    busWrite(8'h04, 32'h0);
    check("R6 irq after clear", 32'(irq), 32'h0);
    busWrite(8'h00, 32'h0);
  endtask

  task automatic tDoorbell;
    logic [31:0] v;
    busWrite(8'h0C, 32'h05);
    busRead(8'h08, v);
    check("R7 doorbell visible", v, 32'h05);
    busRead(8'h0C, v);
    check("R7 doorbell at set alias", v, 32'h05);
    check("R7 no request yet", 32'(fetchReq), 32'h0);
    @(negedge clk);
    check("R7 fetch pulse", 32'(fetchReq), 32'h05);
    busRead(8'h08, v);
    check("R7 doorbell during pulse", v, 32'h05);
    @(negedge clk);
    check("R7 pulse ends", 32'(fetchReq), 32'h0);
    busRead(8'h08, v);
    check("R7 doorbell self-clear", v, 32'h0);
    busWrite(8'h08, 32'hFF);
    busRead(8'h08, v);
    check("R7 status write ignored", v, 32'h0);
    @(negedge clk);
    check("R7 no request from status write", 32'(fetchReq), 32'h0);
  endtask

  task automatic tClkEn;
    logic [31:0] v;
    busWrite(8'h10, 32'hA5);
    check("R8 clkEn outputs", 32'(clkEn), 32'hA5);
    busRead(8'h10, v);
    check("R8 clkEn readback", v, 32'hA5);
    busWrite(8'h14, 32'h0A);
    check("R9 set alias", 32'(clkEn), 32'hAF);
    busWrite(8'h18, 32'h21);
    check("R9 clear alias", 32'(clkEn), 32'h8E);
    busWrite(8'h14, 32'h0);
    busWrite(8'h18, 32'h0);
    check("R9 zero bits no effect", 32'(clkEn), 32'h8E);
    busRead(8'h14, v);
    check("R9 set alias readback", v, 32'h8E);
    busRead(8'h18, v);
    check("R9 clear alias readback", v, 32'h8E);
  endtask

  task automatic tMask;
    logic [31:0] v;
    busWrite(8'h1C, 32'h0000_005A);
    busRead(8'h1C, v);
    check("R10 mask readback", v, 32'h5A);
    busWrite(8'h1C, 32'hFFFF_FFFF);
    busRead(8'h1C, v);
    check("R11 mask upper bits zero", v, 32'hFF);
    busWrite(8'h10, 32'hFFFF_FFFF);
    busRead(8'h10, v);
    check("R11 clkEn upper bits zero", v, 32'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tCtrl();
    tSticky();
    tPending();
    tIrq();
    tDoorbell();
    tClkEn();
    tMask();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule